// File: doc/BRIEF.md
# Output Over-Current Interlock

This block stands between the software-controlled output enables and the physical drivers of a small industrial I/O section. It holds the enables for three low-side digital outputs, one high-side switch and four current-loop inputs. Two digital over-current indications come in from external comparators. One reports the combined sink current of the three digital outputs. The other reports the high-side switch current. Either indication alone, once it has been synchronized and held long enough, forces every one of those drives off. It also wipes the stored enables, raises a sticky fault flag with its interrupt, and lights a fault LED.

Re-arming does not depend on the fault flag. When the over-current condition has gone, software may write the enables again at once. The flag and its interrupt stay set until software clears them with a separate write. Each analog input reports a voltage-mode status bit, which is the inverse of that input's current-loop enable.

Top module: `oc_interlock`

## Requirements
- R1: After reset all drives and loop enables are 0, every voltage-mode bit is 1, and the fault flag, interrupt and LED are 0.
- R2: Each over-current input passes through a 2-stage synchronizer and must then be high for 2 consecutive cycles. An input that rises before a clock edge and stays high shuts the outputs off in the cycle after the 4th edge, and not earlier.
- R3: Either over-current input on its own causes a trip. Only the two summed indications exist, so no single output has a limit of its own.
- R4: A raw over-current pulse lasting one clock cycle causes no trip: drives, flag and LED stay unchanged.
- R5: While a trip is active, all three digital-output drives, the high-side drive and all four loop enables are 0.
- R6: A trip clears the stored enables. After the condition has gone, the outputs stay off until software writes the enables again.
- R7: Enable writes made while a trip is active are ignored. After the condition has gone, the outputs are still 0.
- R8: A trip sets the sticky fault flag. The interrupt output follows the flag, and both stay at 1 until a flag-clear write arrives.
- R9: Once the trip has gone, enable writes take effect on the next edge even if the fault flag is still set.
- R10: The fault LED is on while the flag is set or a trip is active. It goes off after the flag is cleared, provided no trip is active.
- R11: A flag-clear write made while a trip is active leaves the flag set.
- R12: Voltage-mode bit k is the inverse of loop enable k. It is 1 whenever that loop is disabled, whether by software or by a trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oc_sink_raw | input | 1 | Asynchronous indication that the combined sink current of the digital outputs is too high |
| oc_hs_raw | input | 1 | Asynchronous indication that the high-side switch current is too high |
| en_wr | input | 1 | Strobe that writes all the enables below |
| en_dio | input | 3 | Requested enables of the digital outputs |
| en_hs | input | 1 | Requested enable of the high-side switch |
| en_loop | input | 4 | Requested current-loop enables |
| flag_clr | input | 1 | Strobe that clears the fault flag |
| dio_drv | output | 3 | Digital-output drives |
| hs_drv | output | 1 | High-side switch drive |
| loop_en | output | 4 | Current-loop enables |
| volt_mode | output | 4 | Voltage-mode status bits of the analog inputs |
| fault_flag | output | 1 | Sticky fault flag |
| fault_irq | output | 1 | Fault interrupt |
| fault_led | output | 1 | Fault LED drive |

## Verification
The trip path is driven three ways: by the sink indication alone, by the high-side indication alone, and by a one-cycle glitch. The first two show that each input trips on its own, and the glitch shows that a trip needs the qualification window. A held indication is sampled one cycle before and one cycle after the expected shutdown edge, which pins down the synchronizer and qualifier latency exactly. Recovery is tested in two ways. Re-enabling while the flag is still set shows that re-arming and the sticky flag are independent. A clear write made during an active trip, followed by a clear after release, separates a flag that follows the trip from one that only software can reset.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int unsigned NUM_DIO  = 3;
  localparam int unsigned NUM_LOOP = 4;
  localparam int unsigned NUM_SRC  = 2;
  localparam int unsigned EN_W     = NUM_DIO + 1 + NUM_LOOP;

  typedef struct packed {
    logic [NUM_DIO-1:0]  dio;
    logic                hs;
    logic [NUM_LOOP-1:0] loop;
  } en_set_t;

  // Saturating run-length counter of the qualification window
  function automatic logic [7:0] run_next(input logic [7:0] cnt, input logic hit,
                                          input logic [7:0] lim);
    if (!hit)            return 8'd0;
    else if (cnt >= lim) return lim;
    else                 return cnt + 8'd1;
  endfunction
endpackage

// File: rtl/oc_qualifier.sv
module oc_qualifier #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic sync_out,
  output logic qualified
);
  import oc_pkg::*;
  localparam logic [7:0] LIM = 8'(QUAL_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [7:0]             run_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= raw_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 8'd0;
    else        run_q <= run_next(run_q, sync_out, LIM);
  end

  assign qualified = (run_q >= LIM);

  // R4
  qual_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qualified |-> $past(sync_out));
  // R4
  glitch_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qualified && !sync_out) |=> !qualified);
endmodule

// File: rtl/oc_enable_store.sv
module oc_enable_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trip,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (trip) q <= '0;
    else if (wr)   q <= wdata;
  end

  // R6
  trip_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (q == '0));
  // R7
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && wr) |=> (q == '0));
  // R9
  rearm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && wr) |=> (q == $past(wdata)));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && !wr) |=> $stable(q));
endmodule

// File: rtl/oc_fault_flag.sv
module oc_fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (trip) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  // R8
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R11
  clr_during_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && clr) |=> flag);
endmodule

// File: rtl/oc_interlock.sv
module oc_interlock #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       oc_sink_raw,
  input  logic       oc_hs_raw,
  input  logic       en_wr,
  input  logic [2:0] en_dio,
  input  logic       en_hs,
  input  logic [3:0] en_loop,
  input  logic       flag_clr,
  output logic [2:0] dio_drv,
  output logic       hs_drv,
  output logic [3:0] loop_en,
  output logic [3:0] volt_mode,
  output logic       fault_flag,
  output logic       fault_irq,
  output logic       fault_led
);
  import oc_pkg::*;

  logic [NUM_SRC-1:0] raw_v, sync_v, qual_v;
  logic               trip_active;
  en_set_t            req_set, held_set, out_set;

  assign raw_v = {oc_hs_raw, oc_sink_raw};

  generate
    for (genvar c = 0; c < NUM_SRC; c++) begin : g_src
      oc_qualifier #(.SYNC_STAGES(SYNC_STAGES), .QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_v[c]),
        .sync_out(sync_v[c]), .qualified(qual_v[c]));
    end
  endgenerate

  assign trip_active = |qual_v;

  assign req_set = '{dio: en_dio, hs: en_hs, loop: en_loop};

  oc_enable_store #(.W(EN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .trip(trip_active), .wr(en_wr),
    .wdata(req_set), .q(held_set));

  assign out_set = trip_active ? '0 : held_set;

  assign dio_drv   = out_set.dio;
  assign hs_drv    = out_set.hs;
  assign loop_en   = out_set.loop;
  assign volt_mode = ~out_set.loop;

  oc_fault_flag u_flag (
    .clk(clk), .rst_n(rst_n), .trip(trip_active), .clr(flag_clr),
    .flag(fault_flag));

  assign fault_irq = fault_flag;
  assign fault_led = fault_flag | trip_active;

  // R5
  drives_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_active |-> (dio_drv == '0 && !hs_drv && loop_en == '0));
  // R10
  led_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_irq) |-> fault_led);
  // R12
  volt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_active |-> (volt_mode == '1));
  // R3
  either_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_v != '0) |=> fault_flag);
endmodule

// File: tb/oc_interlock_bench.sv
module oc_interlock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oc_sink_raw = 1'b0, oc_hs_raw = 1'b0;
  logic       en_wr = 1'b0, en_hs = 1'b0, flag_clr = 1'b0;
  logic [2:0] en_dio = '0;
  logic [3:0] en_loop = '0;
  logic [2:0] dio_drv;
  logic       hs_drv;
  logic [3:0] loop_en, volt_mode;
  logic       fault_flag, fault_irq, fault_led;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  oc_interlock u_oc_interlock (
    .clk(clk), .rst_n(rst_n), .oc_sink_raw(oc_sink_raw), .oc_hs_raw(oc_hs_raw),
    .en_wr(en_wr), .en_dio(en_dio), .en_hs(en_hs), .en_loop(en_loop),
    .flag_clr(flag_clr), .dio_drv(dio_drv), .hs_drv(hs_drv), .loop_en(loop_en),
    .volt_mode(volt_mode), .fault_flag(fault_flag), .fault_irq(fault_irq),
    .fault_led(fault_led));

  function automatic logic [7:0] outs();
    return {dio_drv, hs_drv, loop_en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_en(input logic [7:0] v);
    {en_dio, en_hs, en_loop} = v;
    en_wr = 1'b1;
    cyc(1);
    en_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 outs", 32'(outs()), 32'h0);
    check("R1 volt_mode", 32'(volt_mode), 32'hF);
    check("R1 flag/irq/led", 32'({fault_flag, fault_irq, fault_led}), 32'h0);
  endtask

  task automatic t_trip(input bit use_hs);
    write_en(8'hFF);
    check("R9 enable write", 32'(outs()), 32'hFF);
    check("R12 volt_mode enabled", 32'(volt_mode), 32'h0);
    if (use_hs) oc_hs_raw = 1'b1; else oc_sink_raw = 1'b1;
    cyc(3);
    check("R2 not before 4th edge", 32'(outs()), 32'hFF);
    cyc(1);
    check(use_hs ? "R3 hs trip" : "R3 sink trip", 32'(outs()), 32'h0);
    check("R5 drives off", 32'({dio_drv, hs_drv, loop_en}), 32'h0);
    check("R12 volt_mode tripped", 32'(volt_mode), 32'hF);
    check("R10 led during trip", 32'(fault_led), 32'h1);
    cyc(1);
    check("R8 flag and irq", 32'({fault_flag, fault_irq}), 32'h3);
    write_en(8'hFF);
    check("R7 write ignored while active", 32'(outs()), 32'h0);
    clear_flag();
    check("R11 clear during trip", 32'(fault_flag), 32'h1);
    oc_hs_raw = 1'b0; oc_sink_raw = 1'b0;
    cyc(6);
    check("R6 enables wiped", 32'(outs()), 32'h0);
    check("R7 blocked write not kept", 32'(loop_en), 32'h0);
    check("R8 flag sticky after release", 32'(fault_irq), 32'h1);
    write_en(8'hA5);
    check("R9 rearm with flag set", 32'(outs()), 32'hA5);
    check("R12 volt_mode follows", 32'(volt_mode), 32'hA);
    check("R10 led still on", 32'(fault_led), 32'h1);
    clear_flag();
    check("R8 flag cleared", 32'({fault_flag, fault_irq}), 32'h0);
    check("R10 led off", 32'(fault_led), 32'h0);
    write_en(8'h00);
  endtask

  task automatic t_glitch();
    write_en(8'h5A);
    oc_sink_raw = 1'b1;
    cyc(1);
    oc_sink_raw = 1'b0;
    cyc(8);
    check("R4 glitch outs", 32'(outs()), 32'h5A);
    check("R4 glitch flag/led", 32'({fault_flag, fault_led}), 32'h0);
    oc_hs_raw = 1'b1;
    cyc(1);
    oc_hs_raw = 1'b0;
    cyc(8);
    check("R4 hs glitch outs", 32'(outs()), 32'h5A);
    write_en(8'h00);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_trip(1'b0);
    t_trip(1'b1);
    t_glitch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule